// File: doc/BRIEF.md
# Width-Overridden Saturating Element ALU

This unit processes one vector element per accepted transfer. Each element carries two raw source operands, each 64 bits wide, with a source width code and a destination width code chosen separately from 8, 16, 32 and 64 bits. The two operands are extended from the source width to an internal width. The operation runs at the larger of the two widths plus a guard bit, so no carry, borrow or sign is lost. Only after that is the wide value clamped or truncated down to the destination width.

The unit supports add, subtract, AND, OR, XOR and a forced-signed add. It can clamp to the unsigned or the signed range of the destination. When asked to record, it reports an overflow bit and the sign class of the final value (zero, negative or positive). The result comes out of a register one cycle after the transfer is accepted, and a plain valid/ready pair provides backpressure.

Top module: `elem_width_alu`

## Requirements
- R1: Width codes are 2 bits (0=64, 1=32, 2=16, 3=8 bits). The operation uses max(source width, destination width) plus a guard bit. For example, unsigned 8-bit 0xFF + 0x01 into a 16-bit destination gives 0x0100.
- R2: Result bits at and above the destination width are always zero. Without saturation, the wide value is simply truncated to the destination width.
- R3: When the operation is signed, each source is first cut to the source width and then sign-extended. Signed 8-bit 0x80 + 0 into 16 bits gives 0xFF80.
- R4: For unsigned operations, sources are zero-extended from the source width. Input bits above the source width have no effect on the result.
- R5: With saturation on, an unsigned result larger than 2^d-1 is clamped to 2^d-1, where d is the destination width.
- R6: With unsigned saturation on, a subtraction that underflows gives zero.
- R7: With signed saturation on, the wide result is clamped to the range -2^(d-1) to 2^(d-1)-1. This also applies to logical opcodes, whose result is then read as signed.
- R8: With record set, the overflow bit is 1 exactly when the delivered value, re-extended to the wide width, differs from the wide result. With record clear, the overflow, eq, lt and gt bits are all 0.
- R9: With record set, exactly one of eq, lt and gt is 1. The choice comes from the delivered destination-width value read as signed, for every opcode.
- R10: in_ready is high when no result is held or when out_ready is high. A result appears one cycle after it is accepted. While out_ready is low, the result stays stable.
- R11: Opcodes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 add that is signed regardless of the signed flag. Codes 6 and 7 give a zero wide result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element can be taken |
| src_a | input | 64 | First raw source element |
| src_b | input | 64 | Second raw source element |
| src_wc | input | 2 | Source width code |
| dst_wc | input | 2 | Destination width code |
| opcode | input | 3 | Operation select |
| signed_en | input | 1 | Treat operands and result as signed |
| sat_en | input | 1 | Clamp instead of truncate |
| rec_en | input | 1 | Produce condition bits |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result |
| out_data | output | 64 | Result, zero above destination width |
| out_ovf | output | 1 | Overflow / saturated |
| out_eq | output | 1 | Result is zero |
| out_lt | output | 1 | Result negative |
| out_gt | output | 1 | Result positive |

## Verification
The assertions assume the consumer eventually raises out_ready. They also assume the width and control inputs are stable during the cycle in which the element is accepted. The stimulus drives inputs only on the falling edge and pulses in_valid for one cycle per element. out_ready is held high, except in one dedicated stall window where it is held low on purpose to show that the result is held. The sweep uses only opcodes 0 to 5, and the reserved codes appear in a directed case.

// File: rtl/elem_alu_pkg.sv
package elem_alu_pkg;

    localparam int DATA_W = 64;
    localparam int WIDE_W = DATA_W + 2;
    localparam int WC_W   = 2;
    localparam int OP_W   = 3;

    typedef logic        [WIDE_W-1:0] wide_u_t;
    typedef logic signed [WIDE_W-1:0] wide_t;

    localparam logic [OP_W-1:0] OP_ADD  = 3'd0;
    localparam logic [OP_W-1:0] OP_SUB  = 3'd1;
    localparam logic [OP_W-1:0] OP_AND  = 3'd2;
    localparam logic [OP_W-1:0] OP_OR   = 3'd3;
    localparam logic [OP_W-1:0] OP_XOR  = 3'd4;
    localparam logic [OP_W-1:0] OP_SADD = 3'd5;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ovf;
        logic              eq;
        logic              lt;
        logic              gt;
    } elem_res_t;

    function automatic int unsigned width_bits(input logic [WC_W-1:0] code);
        return DATA_W >> code;
    endfunction

    function automatic wide_u_t low_mask(input logic [WC_W-1:0] code);
        return (wide_u_t'(1) << width_bits(code)) - wide_u_t'(1);
    endfunction

    function automatic wide_t extend_from(input wide_u_t v, input logic [WC_W-1:0] code,
                                          input logic sgn);
        wide_u_t m;
        wide_u_t lo;
        logic    top;
        m   = low_mask(code);
        lo  = v & m;
        top = lo[width_bits(code) - 1];
        return $signed((sgn && top) ? (lo | ~m) : lo);
    endfunction

endpackage

// File: rtl/elem_src_ext.sv
module elem_src_ext
    import elem_alu_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [WC_W-1:0]   wc,
    input  logic              sgn,
    output wide_t             ext
);
    assign ext = extend_from({2'b00, raw}, wc, sgn);
endmodule

// File: rtl/elem_wide_op.sv
module elem_wide_op
    import elem_alu_pkg::*;
(
    input  wide_t           x,
    input  wide_t           y,
    input  logic [OP_W-1:0] op,
    output wide_t           w
);
    always_comb begin
        unique case (op)
            OP_ADD, OP_SADD: w = x + y;
            OP_SUB:          w = x - y;
            OP_AND:          w = x & y;
            OP_OR:           w = x | y;
            OP_XOR:          w = x ^ y;
            default:         w = '0;
        endcase
    end
endmodule

// File: rtl/elem_narrow.sv
module elem_narrow
    import elem_alu_pkg::*;
(
    input  wide_t           w,
    input  logic [WC_W-1:0] dwc,
    input  logic            sgn,
    input  logic            sat,
    input  logic            rec,
    output elem_res_t       res
);
    wide_u_t m;
    wide_t   hi;
    wide_t   lo;
    wide_t   clamp;
    wide_u_t pick;
    wide_u_t fin_w;
    wide_t   kept;
    wide_t   as_signed;

    always_comb begin
        m     = low_mask(dwc);
        hi    = sgn ? $signed(m >> 1) : $signed(m);
        lo    = sgn ? $signed(~(m >> 1)) : '0;
        clamp = (w > hi) ? hi : ((w < lo) ? lo : w);
        pick  = sat ? wide_u_t'(clamp) : wide_u_t'(w);
        fin_w = pick & m;
        // clamped values always survive re-extension, so one compare covers both modes
        kept      = extend_from(fin_w, dwc, sgn);
        as_signed = extend_from(fin_w, dwc, 1'b1);
        res.data  = fin_w[DATA_W-1:0];
        res.ovf   = rec && (kept != w);
        res.eq    = rec && (as_signed == 0);
        res.lt    = rec && (as_signed < 0);
        res.gt    = rec && (as_signed > 0);
    end
endmodule

// File: rtl/elem_width_alu.sv
module elem_width_alu
    import elem_alu_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [WC_W-1:0]   src_wc,
    input  logic [WC_W-1:0]   dst_wc,
    input  logic [OP_W-1:0]   opcode,
    input  logic              signed_en,
    input  logic              sat_en,
    input  logic              rec_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovf,
    output logic              out_eq,
    output logic              out_lt,
    output logic              out_gt
);
    logic [DATA_W-1:0] raw_src [NSRC];
    wide_t             ext_src [NSRC];
    wide_t             wide_val;
    elem_res_t         res_c;
    elem_res_t         res_q;
    logic              valid_q;
    logic [WC_W-1:0]   dwc_q;
    logic              sgn;
    logic              take;

    assign raw_src[0] = src_a;
    assign raw_src[1] = src_b;
    assign sgn        = signed_en || (opcode == OP_SADD);

    for (genvar i = 0; i < NSRC; i++) begin : g_ext
        elem_src_ext u_ext (
            .raw (raw_src[i]),
            .wc  (src_wc),
            .sgn (sgn),
            .ext (ext_src[i])
        );
    end

    elem_wide_op u_op (
        .x  (ext_src[0]),
        .y  (ext_src[1]),
        .op (opcode),
        .w  (wide_val)
    );

    elem_narrow u_nar (
        .w   (wide_val),
        .dwc (dst_wc),
        .sgn (sgn),
        .sat (sat_en),
        .rec (rec_en),
        .res (res_c)
    );

    assign in_ready = !valid_q || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            dwc_q   <= '0;
        end else if (take) begin
            valid_q <= 1'b1;
            res_q   <= res_c;
            dwc_q   <= dst_wc;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign out_valid = valid_q;
    assign out_data  = res_q.data;
    assign out_ovf   = res_q.ovf;
    assign out_eq    = res_q.eq;
    assign out_lt    = res_q.lt;
    assign out_gt    = res_q.gt;

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((65'(out_data) & ~65'(low_mask(dwc_q))) == 65'd0)); // R2
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_eq, out_lt, out_gt})); // R9
    AST_EQ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_eq) |-> (out_data == '0)); // R9
    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        take |=> out_valid); // R10
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ovf))); // R10
    AST_NO_FLAGS_UNREC: assert property (@(posedge clk) disable iff (rst)
        (take && !rec_en) |=> !(out_ovf || out_eq || out_lt || out_gt)); // R8
endmodule

// File: tb/test_elem_width_alu.sv
module test_elem_width_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [1:0]  src_wc = '0;
    logic [1:0]  dst_wc = '0;
    logic [2:0]  opcode = '0;
    logic        signed_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        rec_en = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_data;
    logic        out_ovf, out_eq, out_lt, out_gt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    elem_width_alu i_elem_width_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .src_a(src_a), .src_b(src_b), .src_wc(src_wc), .dst_wc(dst_wc),
        .opcode(opcode), .signed_en(signed_en), .sat_en(sat_en), .rec_en(rec_en),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ovf(out_ovf), .out_eq(out_eq), .out_lt(out_lt), .out_gt(out_gt)
    );

    task automatic chk(input bit ok, input string tag, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent reference: exact arithmetic in 68 bits
    function automatic logic signed [67:0] ext68(input logic [63:0] x, input int n, input bit s);
        logic [67:0] m;
        logic [67:0] v;
        m = (68'd1 << n) - 68'd1;
        v = {4'b0, x} & m;
        if (s && x[n-1]) v = v | ~m;
        return $signed(v);
    endfunction

    task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sw,
                         input logic [1:0] dw, input logic [2:0] op, input bit sg0,
                         input bit sat, input bit rec, output logic [63:0] r,
                         output logic [3:0] fl);
        bit sg;
        int sn, dn;
        logic signed [67:0] x, y, w, hi, lo, v, back, sv;
        sg = sg0 || (op == 3'd5);
        sn = 64 / (1 << sw);
        dn = 64 / (1 << dw);
        x = ext68(a, sn, sg);
        y = ext68(b, sn, sg);
        case (op)
            3'd0, 3'd5: w = x + y;
            3'd1: w = x - y;
            3'd2: w = x & y;
            3'd3: w = x | y;
            3'd4: w = x ^ y;
            default: w = 0;
        endcase
        if (sg) begin
            hi = (68'sd1 <<< (dn - 1)) - 1;
            lo = -(68'sd1 <<< (dn - 1));
        end else begin
            hi = (68'sd1 <<< dn) - 1;
            lo = 0;
        end
        v = w;
        if (sat) v = (w > hi) ? hi : ((w < lo) ? lo : w);
        r = v[63:0];
        if (dn < 64) r = r & ((64'd1 << dn) - 64'd1);
        back = ext68(r, dn, sg);
        sv = ext68(r, dn, 1'b1);
        fl = rec ? {back != w, sv == 0, sv < 0, sv > 0} : 4'b0;
    endtask

    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sw,
                        input logic [1:0] dw, input logic [2:0] op, input bit sg,
                        input bit sat, input bit rec);
        @(negedge clk);
        src_a = a; src_b = b; src_wc = sw; dst_wc = dw; opcode = op;
        signed_en = sg; sat_en = sat; rec_en = rec; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string tag, input logic [63:0] r, input logic [3:0] fl);
        chk(out_valid === 1'b1, tag, 68'(out_valid), 68'd1);
        chk(out_data === r, tag, 68'(out_data), 68'(r));
        chk({out_ovf, out_eq, out_lt, out_gt} === fl, tag,
            68'({out_ovf, out_eq, out_lt, out_gt}), 68'(fl));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] pat [8];
        logic [63:0] er;
        logic [3:0]  ef;
        pat[0] = 64'h0;                 pat[1] = 64'h1;
        pat[2] = 64'h7F;                pat[3] = 64'h80;
        pat[4] = 64'hFF;                pat[5] = 64'hDEAD_7FFF;
        pat[6] = 64'h8000_0000_8000_8000; pat[7] = 64'hFFFF_FFFF_FFFF_FFFF;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "reset R10", 68'(out_valid), 68'd0);
        chk(in_ready === 1'b1, "reset R10", 68'(in_ready), 68'd1);

        // R1: wider destination keeps the carry
        send(64'hFF, 64'h01, 2'd3, 2'd2, 3'd0, 0, 0, 1);
        expect_out("R1", 64'h100, 4'b0001);
        // R2: narrower destination truncates, discarded bits flagged
        send(64'h1234, 64'h0, 2'd2, 2'd3, 3'd0, 0, 0, 1);
        expect_out("R2", 64'h34, 4'b1001);
        // R3: signed source extension
        send(64'h80, 64'h0, 2'd3, 2'd2, 3'd5, 0, 0, 1);
        expect_out("R3", 64'hFF80, 4'b0010);
        // R4: bits above source width ignored
        send(64'hABCD_12F0, 64'h10, 2'd3, 2'd1, 3'd0, 0, 0, 1);
        expect_out("R4", 64'h100, 4'b0001);
        // R5: unsigned clamp high
        send(64'hF0, 64'h20, 2'd3, 2'd3, 3'd0, 0, 1, 1);
        expect_out("R5", 64'hFF, 4'b1010);
        // R6: unsigned underflow clamps to zero
        send(64'h10, 64'h20, 2'd3, 2'd3, 3'd1, 0, 1, 1);
        expect_out("R6", 64'h0, 4'b1100);
        // R7: signed clamp on logical results
        send(64'h0100, 64'h0, 2'd2, 2'd3, 3'd4, 1, 1, 1);
        expect_out("R7", 64'h7F, 4'b1001);
        send(64'h8000, 64'h0, 2'd2, 2'd3, 3'd3, 1, 1, 1);
        expect_out("R7", 64'h80, 4'b1010);
        // R8: record clear silences flags
        send(64'hF0, 64'h20, 2'd3, 2'd3, 3'd0, 0, 1, 0);
        expect_out("R8", 64'hFF, 4'b0000);
        // R9: zero result
        send(64'h5, 64'h5, 2'd3, 2'd3, 3'd1, 1, 0, 1);
        expect_out("R9", 64'h0, 4'b0100);
        // R11: reserved opcode
        send(64'h55, 64'h66, 2'd0, 2'd0, 3'd7, 0, 0, 1);
        expect_out("R11", 64'h0, 4'b0100);

        // R10: stall holds the result and blocks input
        @(negedge clk);
        out_ready = 1'b0;
        send(64'h7, 64'h9, 2'd3, 2'd3, 3'd0, 0, 0, 1);
        for (int k = 0; k < 3; k++) begin
            chk(in_ready === 1'b0, "R10 stall", 68'(in_ready), 68'd0);
            expect_out("R10", 64'h10, 4'b0001);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 drain", 68'(out_valid), 68'd0);

        // sweep: all width pairs, opcodes, signedness and saturation
        for (int sw = 0; sw < 4; sw++)
            for (int dw = 0; dw < 4; dw++)
                for (int op = 0; op < 6; op++)
                    for (int m = 0; m < 4; m++)
                        for (int p = 0; p < 8; p++) begin
                            model(pat[p], pat[(p * 3 + 1) % 8], 2'(sw), 2'(dw), 3'(op),
                                  m[0], m[1], 1'b1, er, ef);
                            send(pat[p], pat[(p * 3 + 1) % 8], 2'(sw), 2'(dw), 3'(op),
                                 m[0], m[1], 1'b1);
                            expect_out("sweep R1 R2 R3 R4 R5 R6 R7 R8 R9 R11", er, ef);
                        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule